// File: doc/BRIEF.md
# Multi-Ring XOR Sampler Model

This block is a cycle-level, synthesizable model of a random bit source built from several free-running oscillators whose square waves are XOR-combined and then sampled. Each oscillator is replaced by a phase accumulator that counts time in integer picoseconds. Every accumulator has its own programmable period and starting phase. On each clock cycle the model takes one sample instant: it evaluates every oscillator's level, combines the levels, and advances all accumulators by one sample interval.

Two combining arrangements can be selected. In the direct one, the XOR of the live levels is captured. In the registered one, each level is first captured in its own register, and the XOR of those registers is captured one sample later. The sample interval comes either from a fixed period or from an extra reference oscillator divided by eight. A signed picosecond offset can be added to every accumulator on each advance, which models a disturbance shared by all oscillators.

With no offset the output is fully deterministic. This makes the model suited to studying how much pseudo-random structure the arrangement produces by itself. A run stops after a fixed number of samples.

Top module: `xor_ring_sampler`

## Requirements
- R1: For ring j at sample n, let acc = (phase_j + n*step) mod period_j. The ring's level is 1 when 2*acc < period_j and 0 otherwise. Every accumulator holds a value below its period.
- R2: With `mode_cap`=0, the raw bit delivered for sample n is the XOR of all ring levels at sample n.
- R3: With `mode_cap`=1, the raw bit delivered for sample n equals the direct-mode bit of sample n-1. The bit for sample 0 is 0.
- R4: With `src_ring`=0, the base sample interval is the parameter SAMPLE_PS (default 31250 ps, 32 MHz). With `src_ring`=1, it is 8 times `ref_period`.
- R5: The step added to every accumulator per sample is the base interval plus the signed value of `perturb_ps`.
- R6: While `rst` is high at a clock edge, the accumulators load their phases, and `raw_bit`, `raw_valid`, `sample_cnt` and `run_done` become 0.
- R7: Each sample taken increments `sample_cnt` by one. `raw_valid` is 1 in the cycle after each sample is taken.
- R8: After RUN_LEN samples (default 20000), `run_done` is 1 and `raw_valid` is 0. `raw_bit` and `sample_cnt` then hold until reset.
- R9: The ring count N_RINGS is a parameter from 1 upward. With one ring, the raw bit in direct mode is that ring's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample instant per cycle while running |
| rst | input | 1 | Synchronous reset, active high |
| mode_cap | input | 1 | 0: XOR of live levels; 1: per-ring capture ahead of the XOR |
| src_ring | input | 1 | 0: fixed interval SAMPLE_PS; 1: reference ring period times 8 |
| ref_period | input | TW | Reference ring period in ps |
| ring_period | input | N_RINGS*TW | Per-ring period in ps (packed, ring 0 lowest) |
| ring_phase | input | N_RINGS*TW | Per-ring initial phase in ps, below its period |
| perturb_ps | input | PW | Signed offset added to every accumulator per sample |
| raw_bit | output | 1 | Sampled combined bit |
| raw_valid | output | 1 | Strobe: a new raw bit was taken |
| sample_cnt | output | CW | Number of samples taken in this run |
| run_done | output | 1 | Run has reached RUN_LEN samples |

## Verification
On every cycle, the assertions check four things. Each accumulator must stay below its period. In either mode, the delivered bit must match the level XOR that the combiner saw one stage earlier. The counter must advance one step per sample. The valid strobe must match the running state, and everything must stay frozen once the run ends.

Only the bench's scenarios can show that the bit sequences follow the closed-form level equation. The same applies to the exact one-sample shift between the modes, the divided reference interval, and the effect of a signed offset.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef logic [31:0] ps_t;

  localparam int WRAP_STAGES = 8;

  // Level of one ring: high during the first half of its period.
  function automatic logic ring_level(input ps_t acc, input ps_t per);
    logic [32:0] twice;
    twice = {acc, 1'b0};
    return twice < {1'b0, per};
  endfunction

  // Remainder of x by per with restoring subtract-compare stages.
  // Valid for x < per * 2**WRAP_STAGES.
  function automatic ps_t wrap_mod(input ps_t x, input ps_t per);
    logic [39:0] rem;
    logic [39:0] dv;
    rem = {8'd0, x};
    for (int k = WRAP_STAGES - 1; k >= 0; k--) begin
      dv = {8'd0, per} << k;
      if (rem >= dv) rem = rem - dv;
    end
    return rem[31:0];
  endfunction
endpackage

// File: rtl/xrs_step_gen.sv
module xrs_step_gen
  import xrs_pkg::*;
#(
  parameter int          TW        = 20,
  parameter int          PW        = 12,
  parameter int unsigned SAMPLE_PS = 31250
) (
  input  logic                 src_ring,
  input  logic [TW-1:0]        ref_period,
  input  logic signed [PW-1:0] perturb_ps,
  output ps_t                  step
);
  localparam int SW = 34;

  ps_t                 base;
  logic signed [SW-1:0] total;
  logic signed [SW-1:0] offs;

  always_comb begin
    base  = src_ring ? (ps_t'(ref_period) << 3) : ps_t'(SAMPLE_PS);
    offs  = {{(SW-PW){perturb_ps[PW-1]}}, perturb_ps};
    total = $signed({2'b00, base}) + offs;
    step  = total[SW-1] ? '0 : total[31:0];
  end
endmodule

// File: rtl/xrs_ring_acc.sv
module xrs_ring_acc
  import xrs_pkg::*;
#(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [TW-1:0] period,
  input  logic [TW-1:0] phase,
  input  ps_t           step,
  output logic [TW-1:0] acc,
  output logic          level
);
  ps_t sum;
  ps_t nxt;

  always_comb begin
    sum   = ps_t'(acc) + step;
    nxt   = wrap_mod(sum, ps_t'(period));
    level = ring_level(ps_t'(acc), ps_t'(period));
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= phase;
    else if (adv) acc <= nxt[TW-1:0];
  end
endmodule

// File: rtl/xrs_combiner.sv
module xrs_combiner #(
  parameter int N_RINGS = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               mode_cap,
  input  logic [N_RINGS-1:0] levels,
  output logic               raw_bit,
  output logic               xor_now,
  output logic               cap_xor
);
  logic [N_RINGS-1:0] cap_q;

  assign xor_now = ^levels;
  assign cap_xor = ^cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      raw_bit <= 1'b0;
    end else if (adv) begin
      cap_q   <= levels;
      raw_bit <= mode_cap ? cap_xor : xor_now;
    end
  end
endmodule

// File: rtl/xor_ring_sampler.sv
module xor_ring_sampler
  import xrs_pkg::*;
#(
  parameter int          N_RINGS   = 20,
  parameter int          TW        = 20,
  parameter int          PW        = 12,
  parameter int unsigned SAMPLE_PS = 31250,
  parameter int          RUN_LEN   = 20000,
  localparam int         CW        = $clog2(RUN_LEN + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            mode_cap,
  input  logic                            src_ring,
  input  logic [TW-1:0]                   ref_period,
  input  logic [N_RINGS-1:0][TW-1:0]      ring_period,
  input  logic [N_RINGS-1:0][TW-1:0]      ring_phase,
  input  logic signed [PW-1:0]            perturb_ps,
  output logic                            raw_bit,
  output logic                            raw_valid,
  output logic [CW-1:0]                   sample_cnt,
  output logic                            run_done
);
  ps_t                         step;
  logic                        running;
  logic [N_RINGS-1:0]          levels;
  logic [N_RINGS-1:0][TW-1:0]  acc_all;
  logic                        xor_now;
  logic                        cap_xor;

  assign running  = (sample_cnt != CW'(RUN_LEN));
  assign run_done = ~running;

  xrs_step_gen #(.TW(TW), .PW(PW), .SAMPLE_PS(SAMPLE_PS)) u_step (
    .src_ring   (src_ring),
    .ref_period (ref_period),
    .perturb_ps (perturb_ps),
    .step       (step)
  );

  for (genvar j = 0; j < N_RINGS; j++) begin : g_ring
    xrs_ring_acc #(.TW(TW)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .adv    (running),
      .period (ring_period[j]),
      .phase  (ring_phase[j]),
      .step   (step),
      .acc    (acc_all[j]),
      .level  (levels[j])
    );
  end

  xrs_combiner #(.N_RINGS(N_RINGS)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .adv      (running),
    .mode_cap (mode_cap),
    .levels   (levels),
    .raw_bit  (raw_bit),
    .xor_now  (xor_now),
    .cap_xor  (cap_xor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_cnt <= '0;
      raw_valid  <= 1'b0;
    end else begin
      raw_valid <= running;
      if (running) sample_cnt <= sample_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
  parameter int N_RINGS = 20,
  parameter int TW      = 20,
  parameter int CW      = 15,
  parameter int RUN_LEN = 20000
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mode_cap,
  input logic                       raw_bit,
  input logic                       raw_valid,
  input logic [CW-1:0]              sample_cnt,
  input logic                       run_done,
  input logic                       xor_now,
  input logic                       cap_xor,
  input logic [N_RINGS-1:0][TW-1:0] acc_all,
  input logic [N_RINGS-1:0][TW-1:0] ring_period
);
  logic any_oob;
  always_comb begin
    any_oob = 1'b0;
    for (int j = 0; j < N_RINGS; j++)
      if (acc_all[j] >= ring_period[j]) any_oob = 1'b1;
  end

  a_r1_acc_in_range: assert property (@(posedge clk) disable iff (rst)
    !any_oob);

  a_r2_direct_bit: assert property (@(posedge clk) disable iff (rst)
    (!run_done && !mode_cap) |=> raw_bit == $past(xor_now));

  a_r3_capture_stage: assert property (@(posedge clk) disable iff (rst)
    (!run_done && mode_cap) |=> cap_xor == $past(xor_now));

  a_r3_delayed_bit: assert property (@(posedge clk) disable iff (rst)
    (!run_done && mode_cap) |=> raw_bit == $past(cap_xor));

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    !run_done |=> sample_cnt == $past(sample_cnt) + 1'b1);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !run_done |=> raw_valid);

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    run_done |=> run_done && !raw_valid && $stable(raw_bit) && $stable(sample_cnt));

  a_r8_final_count: assert property (@(posedge clk) disable iff (rst)
    run_done |-> sample_cnt == CW'(RUN_LEN));
endmodule

bind xor_ring_sampler xrs_checker #(
  .N_RINGS(N_RINGS), .TW(TW), .CW(CW), .RUN_LEN(RUN_LEN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_cap    (mode_cap),
  .raw_bit     (raw_bit),
  .raw_valid   (raw_valid),
  .sample_cnt  (sample_cnt),
  .run_done    (run_done),
  .xor_now     (xor_now),
  .cap_xor     (cap_xor),
  .acc_all     (acc_all),
  .ring_period (ring_period)
);

// File: tb/xor_ring_sampler_tb.sv
module xor_ring_sampler_tb;
  localparam int N   = 20;
  localparam int TW  = 20;
  localparam int PW  = 12;
  localparam int SPS = 31250;
  localparam int RUN = 20000;
  localparam int CW  = $clog2(RUN + 1);
  localparam int NROWS = 7;

  // Scenario table: mode, source, offset, phase seed, samples checked.
  localparam int T_MODE [NROWS] = '{0, 1, 0, 1, 0, 1, 0};
  localparam int T_SRC  [NROWS] = '{0, 0, 1, 1, 0, 0, 1};
  localparam int T_PERT [NROWS] = '{0, 0, 0, 0, 37, -113, -50};
  localparam int T_SEED [NROWS] = '{1, 1, 2, 2, 3, 3, 4};
  localparam int T_LEN  [NROWS] = '{RUN, 400, 400, 400, 400, 400, 400};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst = 1'b1;
  logic                    mode_cap = 1'b0;
  logic                    src_ring = 1'b0;
  logic [TW-1:0]           ref_period = TW'(5000);
  logic [N-1:0][TW-1:0]    ring_period;
  logic [N-1:0][TW-1:0]    ring_phase;
  logic signed [PW-1:0]    perturb_ps = '0;
  logic                    raw_bit, raw_valid, run_done;
  logic [CW-1:0]           sample_cnt;

  logic [0:0][TW-1:0]      one_period, one_phase;
  logic                    one_bit, one_valid, one_done;
  logic [CW-1:0]           one_cnt;
  assign one_period[0] = ring_period[0];
  assign one_phase[0]  = ring_phase[0];

  xor_ring_sampler #(.N_RINGS(N), .TW(TW), .PW(PW), .SAMPLE_PS(SPS), .RUN_LEN(RUN)) u_dut (
    .clk(clk), .rst(rst), .mode_cap(mode_cap), .src_ring(src_ring),
    .ref_period(ref_period), .ring_period(ring_period), .ring_phase(ring_phase),
    .perturb_ps(perturb_ps), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .sample_cnt(sample_cnt), .run_done(run_done)
  );

  xor_ring_sampler #(.N_RINGS(1), .TW(TW), .PW(PW), .SAMPLE_PS(SPS), .RUN_LEN(RUN)) u_dut1 (
    .clk(clk), .rst(rst), .mode_cap(1'b0), .src_ring(1'b0),
    .ref_period(ref_period), .ring_period(one_period), .ring_phase(one_phase),
    .perturb_ps({PW{1'b0}}), .raw_bit(one_bit), .raw_valid(one_valid),
    .sample_cnt(one_cnt), .run_done(one_done)
  );

  int  n_checks = 0;
  int  n_err    = 0;
  bit  finished = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Closed-form level: high while the phase lies in the first half-period.
  function automatic bit lvl(input int j, input longint n, input longint step);
    longint per = longint'(ring_period[j]);
    longint t   = (longint'(ring_phase[j]) + n * step) % per;
    return (t + t) < per;
  endfunction

  function automatic bit mix(input longint n, input longint step);
    bit b = 1'b0;
    for (int j = 0; j < N; j++) b ^= lvl(j, n, step);
    return b;
  endfunction

  task automatic do_row(input int r);
    longint step;
    bit     exp;
    string  tag;
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    mode_cap   = T_MODE[r][0];
    src_ring   = T_SRC[r][0];
    perturb_ps = PW'(T_PERT[r]);
    for (int j = 0; j < N; j++)
      ring_phase[j] = TW'((T_SEED[r] * 7919 * (j + 1)) % int'(ring_period[j]));
    @(negedge clk);
    chk("R6", "reset raw_bit", raw_bit, 0);
    chk("R6", "reset raw_valid", raw_valid, 0);
    chk("R6", "reset sample_cnt", sample_cnt, 0);
    chk("R6", "reset run_done", run_done, 0);
    rst  = 1'b0;
    step = (T_SRC[r] != 0 ? 8 * longint'(ref_period) : longint'(SPS)) + T_PERT[r];
    if (T_PERT[r] != 0)      tag = "R5";
    else if (T_SRC[r] != 0)  tag = "R4";
    else if (T_MODE[r] != 0) tag = "R3";
    else                     tag = "R2";
    for (int n = 0; n < T_LEN[r]; n++) begin
      @(negedge clk);
      if (T_MODE[r] != 0) exp = (n == 0) ? 1'b0 : mix(n - 1, step);
      else                exp = mix(n, step);
      chk(tag, $sformatf("row %0d bit %0d", r, n), raw_bit, exp);
      chk("R7", "sample_cnt", sample_cnt, n + 1);
      chk("R7", "raw_valid", raw_valid, 1);
      chk("R1 R9", "single ring bit", one_bit, lvl(0, n, SPS));
    end
  endtask

  initial begin
    bit last;
    for (int j = 0; j < N; j++) begin
      ring_period[j] = TW'(4000000 / (790 + j));
      ring_phase[j]  = '0;
    end
    repeat (2) @(negedge clk);
    for (int r = 0; r < NROWS; r++) begin
      do_row(r);
      if (r == 0) begin
        last = raw_bit;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk("R8", "run_done", run_done, 1);
          chk("R8", "raw_valid", raw_valid, 0);
          chk("R8", "sample_cnt", sample_cnt, RUN);
          chk("R8", "raw_bit held", raw_bit, last);
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule